// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block runs complete read transactions against a serial NOR flash from the host side of a four-wire serial bus. One start pulse selects a read type, a 24-bit start address, a byte count and a latency code. The sequencer then produces the whole frame: chip select, a mode-0 serial clock at half the system clock, the 8-bit instruction, the address (and, for the two-line address type, a mode byte), a run of dummy cycles, and the data phase.

Read bytes are handed to the user one at a time over a valid/ready pair. The two shared data lines change direction inside a single frame. The sequencer switches between one-line and two-line transfer as the read type requires. It releases its line drivers at the falling clock edge that ends the last host-driven beat, so that the flash can turn the lines around without contention. When a byte is waiting and the user has not accepted it, the serial clock stops low. No data is lost.

A small table maps each latency code to a dummy-cycle count. It resets to a default mapping and can be rewritten entry by entry.

Top module: `sfr_read_seq`

## Requirements
- R1: After reset cs_n_o is high, sck_o is low, both output enables are low, rd_valid_o is low and busy_o is low.
- R2: sck_o idles low while cs_n_o is high. Each serial clock high phase lasts exactly one clk cycle. Outputs change only at falling edges, and inputs are sampled at rising edges.
- R3: The first 8 beats of every frame carry the instruction on io0 MSB first: 0x0B for cmd_i = 0 (single fast read), 0x3B for cmd_i = 1 (dual output read), 0xBB for cmd_i = 2 (dual I/O read). cmd_i = 3 behaves exactly like cmd_i = 0.
- R4: For cmd 0 and 1 the address follows as 24 beats on io0 MSB first, with io1 not driven. For cmd 2 it follows as 12 beats of two bits, io1 carrying the higher bit (address bit 23 on io1 and bit 22 on io0 in the first beat). These are followed by 4 beats carrying the mode byte (parameter MODE_BYTE, default 0xF0) in the same two-bit order.
- R5: Between the last address/mode beat and the first data beat there are exactly as many dummy beats as the table entry for lat_i gives. The defaults are 8, 4, 2 and 0 for codes 0, 1, 2 and 3. With 0, data starts on the next beat.
- R6: A clk cycle with map_we_i high writes map_val_i into the entry for map_code_i. Later frames using that code run with the new dummy count, and other codes keep theirs.
- R7: Both output enables drop at the falling edge ending the last address/mode beat and stay low through the dummy and data beats. io1_oe_o is high only during the address and mode beats of cmd 2.
- R8: Data bytes arrive MSB first. For cmd 0 and 3 each beat samples io1_i only, and io0_i is ignored. For cmd 1 and 2 each beat samples two bits, io1_i the higher.
- R9: A frame delivers exactly len_i + 1 bytes. cs_n_o rises at the falling edge that ends the last data beat.
- R10: Once rd_valid_o is high it stays high with rd_data_o unchanged until rd_ready_i is high. While a byte waits unaccepted, sck_o does not rise.
- R11: start_i is accepted only while busy_o is low. A start pulse during a frame has no effect on that frame and starts no further frame.
- R12: cs_n_o stays low for the whole frame, including the dummy beats, so each command produces exactly one low pulse of cs_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start strobe, accepted when not busy |
| cmd_i | input | 2 | Read type: 0 single, 1 dual output, 2 dual I/O, 3 as 0 |
| addr_i | input | 24 | Start byte address |
| len_i | input | LEN_W | Number of bytes minus one |
| lat_i | input | 2 | Latency code selecting a dummy count |
| map_we_i | input | 1 | Write strobe for the latency table |
| map_code_i | input | 2 | Latency table entry to write |
| map_val_i | input | 4 | Dummy count to store |
| busy_o | output | 1 | Frame in progress or byte pending |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid |
| rd_ready_i | input | 1 | User accepts read byte |
| sck_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Chip select, active low |
| io0_o | output | 1 | Line 0 output value |
| io0_oe_o | output | 1 | Line 0 output enable |
| io1_o | output | 1 | Line 1 output value |
| io1_oe_o | output | 1 | Line 1 output enable |
| io0_i | input | 1 | Line 0 input value |
| io1_i | input | 1 | Line 1 input value |

## Verification
The assertions watch, on every cycle, that the serial clock is low whenever chip select is high. They also check that neither line is driven during dummy or data beats, that io1 is driven only by the dual I/O type, that a pending byte holds its value and freezes the clock, and that chip select only rises out of the data phase. The bench alone can show the instruction, address and mode bits in their order on the wire, and the exact dummy count for every read type and latency code, including zero and rewritten entries. It also shows the byte values assembled from one or two lines, the byte count, and that a start pulse during a frame is ignored.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int SFR_ADDR_W  = 24;
  localparam int SFR_DUMMY_W = 4;
  localparam int SFR_BEAT_W  = 5;

  typedef enum logic [1:0] {
    CMD_FAST = 2'd0,
    CMD_DOUT = 2'd1,
    CMD_DIO  = 2'd2,
    CMD_RSVD = 2'd3
  } sfr_cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_MODE, PH_DUMMY, PH_DATA, PH_END
  } sfr_phase_e;

  function automatic logic [7:0] opcode_of(sfr_cmd_e c);
    case (c)
      CMD_DOUT: return 8'h3B;
      CMD_DIO:  return 8'hBB;
      default:  return 8'h0B;
    endcase
  endfunction

  function automatic logic addr_two_line(sfr_cmd_e c);
    return c == CMD_DIO;
  endfunction

  function automatic logic data_two_line(sfr_cmd_e c);
    return (c == CMD_DOUT) || (c == CMD_DIO);
  endfunction

  // beats per byte minus one
  function automatic logic [2:0] bpb_m1(sfr_cmd_e c);
    return data_two_line(c) ? 3'd3 : 3'd7;
  endfunction

  function automatic sfr_phase_e phase_after(sfr_phase_e p, sfr_cmd_e c,
                                             logic [SFR_DUMMY_W-1:0] dummy);
    case (p)
      PH_CMD:   return PH_ADDR;
      PH_ADDR:  return addr_two_line(c) ? PH_MODE
                       : ((dummy != '0) ? PH_DUMMY : PH_DATA);
      PH_MODE:  return (dummy != '0) ? PH_DUMMY : PH_DATA;
      PH_DUMMY: return PH_DATA;
      PH_DATA:  return PH_END;
      default:  return PH_IDLE;
    endcase
  endfunction

  function automatic logic [SFR_BEAT_W-1:0] beats_of(sfr_phase_e p, sfr_cmd_e c,
                                                     logic [SFR_DUMMY_W-1:0] dummy);
    case (p)
      PH_CMD:   return SFR_BEAT_W'(8);
      PH_ADDR:  return addr_two_line(c) ? SFR_BEAT_W'(SFR_ADDR_W / 2) : SFR_BEAT_W'(SFR_ADDR_W);
      PH_MODE:  return SFR_BEAT_W'(4);
      PH_DUMMY: return SFR_BEAT_W'(dummy);
      default:  return '0;
    endcase
  endfunction

  function automatic logic drives_io0(sfr_phase_e p);
    return (p == PH_CMD) || (p == PH_ADDR) || (p == PH_MODE);
  endfunction

  function automatic logic drives_io1(sfr_phase_e p, sfr_cmd_e c);
    return ((p == PH_ADDR) || (p == PH_MODE)) && addr_two_line(c);
  endfunction

  function automatic logic [SFR_DUMMY_W-1:0] default_dummy(int code, int n_codes);
    return (code == n_codes - 1) ? '0 : SFR_DUMMY_W'(8 >> code);
  endfunction

endpackage

// File: rtl/sfr_lat_map.sv
module sfr_lat_map
  import sfr_pkg::*;
#(
  parameter int LAT_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [LAT_W-1:0]       wcode_i,
  input  logic [SFR_DUMMY_W-1:0] wval_i,
  input  logic [LAT_W-1:0]       code_i,
  output logic [SFR_DUMMY_W-1:0] dummy_o
);
  localparam int N = 1 << LAT_W;

  logic [SFR_DUMMY_W-1:0] map_q [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        map_q[g] <= default_dummy(g, N);
      else if (we_i && (wcode_i == LAT_W'(g)))
        map_q[g] <= wval_i;
    end
  end

  assign dummy_o = map_q[code_i];
endmodule

// File: rtl/sfr_tx_shift.sv
module sfr_tx_shift #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         two_i,
  output logic         hi_o,
  output logic         nx_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (load_i)  sh_q <= load_val_i;
    else if (shift_i) sh_q <= two_i ? {sh_q[W-3:0], 2'b00} : {sh_q[W-2:0], 1'b0};
  end

  assign hi_o = sh_q[W-1];
  assign nx_o = sh_q[W-2];
endmodule

// File: rtl/sfr_rx_pack.sv
module sfr_rx_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_i,
  input  logic       two_i,
  input  logic       io0_i,
  input  logic       io1_i,
  output logic [7:0] nxt_o
);
  logic [7:0] sh_q;

  assign nxt_o = two_i ? {sh_q[5:0], io1_i, io0_i} : {sh_q[6:0], io1_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (sample_i) sh_q <= nxt_o;
  end
endmodule

// File: rtl/sfr_read_seq.sv
module sfr_read_seq
  import sfr_pkg::*;
#(
  parameter int         LEN_W     = 8,
  parameter int         LAT_W     = 2,
  parameter logic [7:0] MODE_BYTE = 8'hF0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [1:0]             cmd_i,
  input  logic [SFR_ADDR_W-1:0]  addr_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [LAT_W-1:0]       lat_i,
  input  logic                   map_we_i,
  input  logic [LAT_W-1:0]       map_code_i,
  input  logic [SFR_DUMMY_W-1:0] map_val_i,
  output logic                   busy_o,
  output logic [7:0]             rd_data_o,
  output logic                   rd_valid_o,
  input  logic                   rd_ready_i,
  output logic                   sck_o,
  output logic                   cs_n_o,
  output logic                   io0_o,
  output logic                   io0_oe_o,
  output logic                   io1_o,
  output logic                   io1_oe_o,
  input  logic                   io0_i,
  input  logic                   io1_i
);
  localparam int TX_W = 8 + SFR_ADDR_W + 8;

  sfr_phase_e             ph_q, ph_nxt;
  sfr_cmd_e               cmd_q, cmd_eff;
  logic                   half_q, sck_q, cs_n_q, oe0_q, oe1_q, valid_q, last_q;
  logic [SFR_BEAT_W-1:0]  beats_q;
  logic [SFR_DUMMY_W-1:0] dummy_q, map_dummy;
  logic [2:0]             bits_q;
  logic [LEN_W-1:0]       bytes_q;
  logic [7:0]             data_q, rx_next;
  logic                   tx_hi, tx_nx;

  // named internal events
  logic ev_start, in_frame, ev_hold, ev_rise, ev_fall, ev_sample, ev_byte, ev_pop;
  logic tx_phase, two_tx, ev_ph_end;

  assign cmd_eff   = (cmd_i == 2'd3) ? CMD_FAST : sfr_cmd_e'(cmd_i);
  assign ev_start  = (ph_q == PH_IDLE) && start_i && !valid_q;
  assign in_frame  = (ph_q == PH_CMD) || (ph_q == PH_ADDR) || (ph_q == PH_MODE) ||
                     (ph_q == PH_DUMMY) || (ph_q == PH_DATA);
  assign ev_hold   = valid_q && !rd_ready_i;
  assign ev_rise   = in_frame && !half_q && !((ph_q == PH_DATA) && ev_hold);
  assign ev_fall   = in_frame && half_q;
  assign ev_sample = ev_rise && (ph_q == PH_DATA);
  assign ev_byte   = ev_sample && (bits_q == 3'd0);
  assign ev_pop    = valid_q && rd_ready_i;
  assign tx_phase  = drives_io0(ph_q);
  assign two_tx    = drives_io1(ph_q, cmd_q);
  assign ev_ph_end = ev_fall && ((ph_q == PH_DATA) ? last_q : (beats_q == SFR_BEAT_W'(1)));
  assign ph_nxt    = phase_after(ph_q, cmd_q, dummy_q);

  sfr_lat_map #(.LAT_W(LAT_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (map_we_i),
    .wcode_i (map_code_i),
    .wval_i  (map_val_i),
    .code_i  (lat_i),
    .dummy_o (map_dummy)
  );

  sfr_tx_shift #(.W(TX_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ev_start),
    .load_val_i ({opcode_of(cmd_eff), addr_i, MODE_BYTE}),
    .shift_i    (ev_fall && tx_phase),
    .two_i      (two_tx),
    .hi_o       (tx_hi),
    .nx_o       (tx_nx)
  );

  sfr_rx_pack u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (ev_sample),
    .two_i    (data_two_line(cmd_q)),
    .io0_i    (io0_i),
    .io1_i    (io1_i),
    .nxt_o    (rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cmd_q   <= CMD_FAST;
      half_q  <= 1'b0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      oe0_q   <= 1'b0;
      oe1_q   <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      beats_q <= '0;
      dummy_q <= '0;
      bits_q  <= '0;
      bytes_q <= '0;
      data_q  <= '0;
    end else begin
      if (ev_start) begin
        cmd_q   <= cmd_eff;
        dummy_q <= map_dummy;
        bytes_q <= len_i;
        ph_q    <= PH_CMD;
        beats_q <= beats_of(PH_CMD, cmd_eff, map_dummy);
        cs_n_q  <= 1'b0;
        half_q  <= 1'b0;
        sck_q   <= 1'b0;
        oe0_q   <= 1'b1;
        oe1_q   <= 1'b0;
        last_q  <= 1'b0;
      end
      if (ev_rise) begin
        sck_q  <= 1'b1;
        half_q <= 1'b1;
      end
      if (ev_sample) begin
        if (bits_q == 3'd0) begin
          bits_q <= bpb_m1(cmd_q);
          if (bytes_q == '0) last_q  <= 1'b1;
          else               bytes_q <= bytes_q - 1'b1;
        end else begin
          bits_q <= bits_q - 3'd1;
        end
      end
      if (ev_fall) begin
        sck_q  <= 1'b0;
        half_q <= 1'b0;
        if (ev_ph_end) begin
          ph_q    <= ph_nxt;
          beats_q <= beats_of(ph_nxt, cmd_q, dummy_q);
          oe0_q   <= drives_io0(ph_nxt);
          oe1_q   <= drives_io1(ph_nxt, cmd_q);
          bits_q  <= bpb_m1(cmd_q);
          if (ph_nxt == PH_END) cs_n_q <= 1'b1;
        end else if (ph_q != PH_DATA) begin
          beats_q <= beats_q - 1'b1;
        end
      end
      if (ph_q == PH_END) ph_q <= PH_IDLE;
      if (ev_byte) begin
        data_q  <= rx_next;
        valid_q <= 1'b1;
      end else if (ev_pop) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign busy_o     = (ph_q != PH_IDLE) || valid_q;
  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;
  assign sck_o      = sck_q;
  assign cs_n_o     = cs_n_q;
  assign io0_oe_o   = oe0_q;
  assign io1_oe_o   = oe1_q;
  assign io0_o      = oe0_q & (two_tx ? tx_nx : tx_hi);
  assign io1_o      = oe1_q & tx_hi;

  // R2: clock parked low whenever the flash is deselected
  a_r2_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);

  // R7: no host drive while the flash may own the lines
  a_r7_released_dummy_data: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_DUMMY) || (ph_q == PH_DATA)) |-> (!io0_oe_o && !io1_oe_o));

  // R7: line 1 driven only by the two-line address type
  a_r7_io1_dio_only: assert property (@(posedge clk) disable iff (!rst_n)
    io1_oe_o |-> (cmd_q == CMD_DIO) && !cs_n_o);

  // R10: pending byte freezes the serial clock
  a_r10_stall_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> !$rose(sck_o));

  // R10: pending byte keeps its value
  a_r10_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> (rd_valid_o && $stable(rd_data_o)));

  // R12: chip select rises only out of the data phase
  a_r12_cs_end_from_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> $past(ph_q == PH_DATA));

endmodule

// File: tb/sfr_read_seq_tb_top.sv
`timescale 1ns/1ps
module sfr_read_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  cmd_i = '0;
  logic [23:0] addr_i = '0;
  logic [7:0]  len_i = '0;
  logic [1:0]  lat_i = '0;
  logic        map_we_i = 1'b0;
  logic [1:0]  map_code_i = '0;
  logic [3:0]  map_val_i = '0;
  logic        busy_o, rd_valid_o, sck_o, cs_n_o;
  logic [7:0]  rd_data_o;
  logic        rd_ready_i = 1'b1;
  logic        io0_o, io0_oe_o, io1_o, io1_oe_o;
  logic        io0_i = 1'b0, io1_i = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sfr_read_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .addr_i(addr_i),
    .len_i(len_i), .lat_i(lat_i), .map_we_i(map_we_i), .map_code_i(map_code_i),
    .map_val_i(map_val_i), .busy_o(busy_o), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .sck_o(sck_o), .cs_n_o(cs_n_o),
    .io0_o(io0_o), .io0_oe_o(io0_oe_o), .io1_o(io1_o), .io1_oe_o(io1_oe_o),
    .io0_i(io0_i), .io1_i(io1_i)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  int model_map [4] = '{8, 4, 2, 0};

  // expectations of the current frame
  int exp_eff, exp_hdr_tx, exp_hdr, exp_bpb, exp_nbeats, exp_dummy;
  logic [23:0] exp_addr;
  // observations
  int k, oe_bad, frames, rx_idx, data_bad, stall_bad, hw, hw_bad, rises;
  int first_act, first_exp;
  logic [7:0] cap_op, cap_mode;
  logic [23:0] cap_addr;
  bit stall_mode = 0, prev_hold = 0, prev_sck = 0;
  logic [7:0] prev_data;
  int dd, bi, wi;
  logic [7:0] vv;

  function automatic logic [7:0] pat(logic [23:0] a, int i);
    return (a[7:0] ^ 8'h5A) + a[15:8] + 8'(i * 29);
  endfunction

  function automatic logic [7:0] exp_op(int eff);
    return (eff == 2) ? 8'hBB : (eff == 1) ? 8'h3B : 8'h0B;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // flash model: capture host beats on rising edges
  always @(posedge sck_o) begin
    #1;
    rises++;
    if (k < 8) cap_op = {cap_op[6:0], io0_o};
    else if (k < exp_hdr_tx) begin
      if (exp_eff == 2) begin
        if (k < 20) cap_addr = {cap_addr[21:0], io1_o, io0_o};
        else        cap_mode = {cap_mode[5:0], io1_o, io0_o};
      end else begin
        cap_addr = {cap_addr[22:0], io0_o};
      end
    end
    if (k < exp_hdr_tx) begin
      if (!io0_oe_o || (io1_oe_o != (exp_eff == 2 && k >= 8))) oe_bad++;
    end else if (io0_oe_o || io1_oe_o) oe_bad++;
    k++;
  end

  // flash model: present data after each falling edge
  always @(negedge sck_o) begin
    #1;
    dd = k - exp_hdr;
    if (dd >= 0 && dd < exp_nbeats) begin
      bi = dd / exp_bpb;
      wi = dd % exp_bpb;
      vv = pat(exp_addr, bi);
      if (exp_bpb == 8) begin
        io1_i = vv[7 - wi];
        io0_i = 1'($urandom);
      end else begin
        io1_i = vv[7 - 2*wi];
        io0_i = vv[6 - 2*wi];
      end
    end
  end

  always @(negedge cs_n_o) frames++;

  // user side: ready pattern, collection, stall and clock-shape checks
  always @(negedge clk) begin
    if (sck_o) hw++;
    else begin
      if (hw > 1) hw_bad++;
      hw = 0;
    end
    if (prev_hold) begin
      if (!rd_valid_o || rd_data_o != prev_data) stall_bad++;
      if (sck_o && !prev_sck) stall_bad++;
    end
    rd_ready_i = stall_mode ? ($urandom_range(0, 4) == 0) : 1'b1;
    if (rd_valid_o && rd_ready_i) begin
      if (rd_data_o != pat(exp_addr, rx_idx)) begin
        if (data_bad == 0) begin
          first_act = rd_data_o;
          first_exp = pat(exp_addr, rx_idx);
        end
        data_bad++;
      end
      rx_idx++;
    end
    prev_hold = rd_valid_o && !rd_ready_i;
    prev_data = rd_data_o;
    prev_sck  = sck_o;
  end

  task automatic map_write(input int code, input int val);
    @(negedge clk);
    map_we_i = 1; map_code_i = code[1:0]; map_val_i = val[3:0];
    @(negedge clk);
    map_we_i = 0;
    model_map[code] = val;
  endtask

  task automatic run(input int c, input int lat, input logic [23:0] a, input int len,
                     input bit stall, input bit poke);
    int guard;
    exp_eff    = (c == 3) ? 0 : c;
    exp_dummy  = model_map[lat];
    exp_hdr_tx = 8 + ((exp_eff == 2) ? 16 : 24);
    exp_hdr    = exp_hdr_tx + exp_dummy;
    exp_bpb    = (exp_eff == 0) ? 8 : 4;
    exp_nbeats = (len + 1) * exp_bpb;
    exp_addr   = a;
    k = 0; cap_op = 0; cap_addr = 0; cap_mode = 0; oe_bad = 0; frames = 0;
    rx_idx = 0; data_bad = 0; stall_bad = 0;
    @(negedge clk);
    stall_mode = stall;
    start_i = 1; cmd_i = c[1:0]; addr_i = a; len_i = len[7:0]; lat_i = lat[1:0];
    @(negedge clk);
    start_i = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1; cmd_i = ~c[1:0]; addr_i = ~a; lat_i = ~lat[1:0];
      @(negedge clk);
      start_i = 0;
    end
    guard = 0;
    while (busy_o && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    stall_mode = 0;
    repeat (30) @(negedge clk);
    check(guard < 20000, "R9 frame completes", guard, 20000);
    check(cap_op == exp_op(exp_eff), "R3 instruction byte", cap_op, exp_op(exp_eff));
    check(cap_addr == a, "R4 address bits", cap_addr, a);
    if (exp_eff == 2) check(cap_mode == 8'hF0, "R4 mode byte", cap_mode, 8'hF0);
    check(k == exp_hdr + exp_nbeats, "R5 beat count incl. dummy", k, exp_hdr + exp_nbeats);
    check(rx_idx == len + 1, "R9 byte count", rx_idx, len + 1);
    check(data_bad == 0, "R8 read data", first_act, first_exp);
    check(oe_bad == 0, "R7 output enables per beat", oe_bad, 0);
    check(frames == 1 && cs_n_o && !io0_oe_o && !io1_oe_o, "R12 one frame, released after",
          frames, 1);
    if (stall) check(stall_bad == 0, "R10 stall holds byte and clock", stall_bad, 0);
    if (poke)  check(frames == 1, "R11 start while busy ignored", frames, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    exp_eff = 0; exp_hdr_tx = 1000; exp_hdr = 1000; exp_bpb = 8; exp_nbeats = 0;
    exp_addr = 0; hw = 0; hw_bad = 0; rises = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle state after reset
    check(cs_n_o == 1'b1, "R1 cs_n high", cs_n_o, 1);
    check(sck_o == 1'b0, "R1 sck low", sck_o, 0);
    check(!io0_oe_o && !io1_oe_o, "R1 enables low", {io1_oe_o, io0_oe_o}, 0);
    check(!rd_valid_o, "R1 valid low", rd_valid_o, 0);
    check(!busy_o, "R1 not busy", busy_o, 0);

    // sweep all types, latency codes and two lengths
    for (int c = 0; c < 4; c++)
      for (int lat = 0; lat < 4; lat++)
        for (int li = 0; li < 2; li++)
          run(c, lat, 24'hA5C300 ^ 24'(c << 20) ^ 24'(lat << 9) ^ 24'(li * 77),
              li * 3, (li == 1) && lat[0], 0);

    // R6: rewritten latency entries
    map_write(1, 6);
    run(1, 1, 24'h123456, 1, 0, 0);
    check(k == exp_hdr_tx + 6 + 2 * 4, "R6 rewritten code 1 gives 6 dummies",
          k, exp_hdr_tx + 6 + 8);
    map_write(3, 1);
    run(2, 3, 24'h00FF81, 0, 0, 0);
    check(k == exp_hdr_tx + 1 + 4, "R6 rewritten code 3 gives 1 dummy", k, exp_hdr_tx + 5);
    run(0, 2, 24'h7E0042, 1, 0, 0);
    check(k == exp_hdr_tx + 2 + 16, "R6 untouched code 2 keeps 2 dummies",
          k, exp_hdr_tx + 18);

    // R11: start pulse inside a frame
    run(0, 0, 24'h3C3C3C, 2, 0, 1);
    run(2, 3, 24'hC001D0, 1, 0, 1);

    // R10: long read under heavy back-pressure
    run(1, 2, 24'h0BEEF0, 15, 1, 0);
    run(0, 0, 24'h55AA11, 7, 1, 0);

    check(hw_bad == 0 && rises > 0, "R2 one-cycle high phase", hw_bad, 0);
    summary();
    $finish;
  end
endmodule